// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block is the master side of a parallel flash-programming link to a microcontroller. It drives a 16-bit address bus, an 8-bit write-data bus, a 4-bit mode code and an active-low program strobe. It reads 8-bit data back from the target. A host starts a session by giving a page count and the signature bytes it expects. It then streams page contents over a valid/ready handshake, 128 bytes per page by default.

A session first reads each signature byte and compares it with the expected value. A mismatch ends the session in an error state, and no strobe pulse is issued. The sequencer then reads the security byte. If that byte is anything other than FFh, a recovery runs before any page work:

1. Unlock.
2. Erase the whole array.
3. Write FFh to the security byte.
4. Restore the signature bytes, because the erase destroyed them.
5. Lock.

Each page is then written in three phases:

- An unlock.
- One page-load pulse per byte.
- A second unlock, followed by a commit pulse.

A final lock ends the session, and `done` is raised.

Every write operation holds its mode, address and data for a parameterised setup time before the strobe falls. It keeps them unchanged while the strobe is low for a parameterised width, and for a hold time after the strobe rises. A read drives its mode and address for the setup time and then samples the target's data, without a strobe.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, `tgt_strobe_n` is 1, `tgt_mode` is 0 (idle), `tgt_wdata_oe`, `in_ready`, `busy`, `done` and `error` are 0.
- R2: A session reads signature byte i with mode 1 at address i (i = 0 upward), and compares it with `sig_expected[8i+7:8i]`. On any mismatch the session stops with `error` = 1, and not a single strobe pulse is issued.
- R3: The security byte is read with mode 2. When it reads FFh, no recovery step is issued, and the first pulse is the page unlock (or the final lock when the page count is 0).
- R4: When the security byte is not FFh, the first seven pulses are, in order:
  1. Mode 3 with data 55h.
  2. Mode 3 with data AAh.
  3. Mode 4 (erase).
  4. Mode 5 with data FFh.
  5. One mode-6 pulse per signature byte, at address i with the expected byte i as data.
  6. Mode 7 (lock).
- R5: Each page p is written in this order:
  1. Mode 3 with 55h, then mode 3 with AAh.
  2. PAGE_BYTES pulses of mode 8, at address p*PAGE_BYTES+i carrying host byte i.
  3. Mode 3 with 55h, then mode 3 with AAh.
  4. Mode 9 at address p*PAGE_BYTES.
- R6: Mode, address and data are held for at least SETUP_CYC clock cycles with the strobe high before it falls. They stay unchanged while the strobe is low. The strobe stays low for exactly WIDTH_CYC cycles.
- R7: A host byte is taken in the cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 0 in the following cycle. Bytes are used in arrival order, exactly PAGE_BYTES per page.
- R8: After the last commit, one mode-7 pulse is issued. Then `done` = 1 and `busy` = 0, and both hold until the next accepted start.
- R9: While `error` is 1, the strobe stays high and `busy` is 0. The flag holds until the next accepted start.
- R10: `start` is ignored while `busy` is 1. The running session is not restarted and emits no extra pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a session (ignored while busy) |
| num_pages | input | PAGE_CNT_W | Number of pages to program, captured at start |
| sig_expected | input | SIG_BYTES*8 | Expected signature bytes, byte i at bits 8i+7:8i |
| in_valid | input | 1 | Host page byte available |
| in_data | input | 8 | Host page byte |
| in_ready | output | 1 | Sequencer accepts a page byte |
| tgt_rdata | input | 8 | Data read back from the target |
| tgt_mode | output | 4 | Operation mode code presented to the target |
| tgt_addr | output | ADDR_W | Address presented to the target |
| tgt_wdata | output | 8 | Write data presented to the target |
| tgt_wdata_oe | output | 1 | Write data bus driven (write operations) |
| tgt_strobe_n | output | 1 | Active-low program pulse |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session completed successfully |
| error | output | 1 | Session aborted on signature mismatch |

## Verification
The timing of each result is tied to a clock edge:

- A new mode/address/data value is registered on a clock edge. The strobe falls SETUP_CYC+1 edges later, rises WIDTH_CYC edges after that, and the next operation's values appear HOLD_CYC+2 edges after the rise.
- A read samples `tgt_rdata` SETUP_CYC+2 edges after its address is driven.
- `in_ready` rises one edge after the byte-wait state is entered, and drops on the edge that takes the byte.

The bench samples every output on the falling clock edge, after all registered updates have settled. It logs each strobe pulse as an event carrying the mode, address and data, rather than counting cycles to it. A monitor counts the high and low falling-edge samples around each pulse to check the setup and width windows. `done` and `error` are polled until one of them rises.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [3:0] {
    MD_IDLE      = 4'd0,
    MD_SIG_RD    = 4'd1,
    MD_SEC_RD    = 4'd2,
    MD_UNLOCK    = 4'd3,
    MD_ERASE     = 4'd4,
    MD_SEC_WR    = 4'd5,
    MD_SIG_WR    = 4'd6,
    MD_LOCK      = 4'd7,
    MD_PG_LOAD   = 4'd8,
    MD_PG_COMMIT = 4'd9
  } prog_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SIG_RD, ST_SEC_RD, ST_UNLK_A, ST_UNLK_B, ST_ERASE,
    ST_SEC_WR, ST_SIG_WR, ST_LOCK, ST_WAIT_BYTE, ST_LOAD, ST_COMMIT,
    ST_DONE, ST_ERROR
  } seq_state_e;

  typedef enum logic [1:0] {
    RET_ERASE, RET_LOAD, RET_COMMIT
  } unlock_ret_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [7:0] BYTE_BLANK = 8'hFF;

endpackage

// File: rtl/prog_step_counter.sv
module prog_step_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         last
);

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assign last = (count == limit);

endmodule

// File: rtl/prog_strobe_gen.sv
module prog_strobe_gen #(
  parameter int SETUP_CYC = 2,
  parameter int WIDTH_CYC = 3,
  parameter int HOLD_CYC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic with_pulse,
  output logic strobe_n,
  output logic fin
);

  localparam int MAX_A = (SETUP_CYC > WIDTH_CYC) ? SETUP_CYC : WIDTH_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD} phase_e;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      pulse_q  <= 1'b0;
      strobe_n <= 1'b1;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (phase)
        PH_IDLE: if (go) begin
          phase   <= PH_SETUP;
          cnt     <= CNT_W'(SETUP_CYC - 1);
          pulse_q <= with_pulse;
        end
        PH_SETUP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (pulse_q) begin
            phase    <= PH_LOW;
            strobe_n <= 1'b0;
            cnt      <= CNT_W'(WIDTH_CYC - 1);
          end else begin
            phase <= PH_IDLE;
            fin   <= 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            phase    <= PH_HOLD;
            strobe_n <= 1'b1;
            cnt      <= CNT_W'(HOLD_CYC - 1);
          end
        end
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            phase <= PH_IDLE;
            fin   <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 128,
  parameter int SIG_BYTES  = 2,
  parameter int PAGE_CNT_W = 8,
  parameter int SETUP_CYC  = 2,
  parameter int WIDTH_CYC  = 3,
  parameter int HOLD_CYC   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [PAGE_CNT_W-1:0]  num_pages,
  input  logic [SIG_BYTES*8-1:0] sig_expected,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  output logic                   in_ready,
  input  logic [7:0]             tgt_rdata,
  output logic [3:0]             tgt_mode,
  output logic [ADDR_W-1:0]      tgt_addr,
  output logic [7:0]             tgt_wdata,
  output logic                   tgt_wdata_oe,
  output logic                   tgt_strobe_n,
  output logic                   busy,
  output logic                   done,
  output logic                   error
);

  localparam int BYTE_IDX_W = $clog2(PAGE_BYTES);
  localparam int SIG_IDX_W  = (SIG_BYTES > 1) ? $clog2(SIG_BYTES) : 1;

  seq_state_e               state;
  unlock_ret_e              unlk_ret;
  logic                     lock_final;
  logic                     issued;
  logic                     go;
  logic                     pulse_req;
  logic                     pulse_fin;
  logic [PAGE_CNT_W-1:0]    pages_q;
  logic [7:0]               byte_q;

  logic [SIG_IDX_W-1:0]     sig_cnt;
  logic                     sig_last;
  logic [BYTE_IDX_W-1:0]    byte_cnt;
  logic                     byte_last;
  logic [PAGE_CNT_W-1:0]    page_cnt;
  logic                     page_last;

  logic                     in_session, start_acc, op_done, launch;
  logic                     sig_clr, sig_inc, byte_clr, byte_inc, page_inc;
  logic [7:0]               sig_byte;
  prog_mode_e               op_mode;
  logic [ADDR_W-1:0]        op_addr;
  logic [7:0]               op_data;
  logic                     op_pulse, op_state;

  always_comb begin
    in_session = !(state inside {ST_IDLE, ST_DONE, ST_ERROR});
    start_acc  = start && !in_session;
    op_done    = issued && pulse_fin;
    sig_clr    = start_acc || (state == ST_SEC_WR && op_done);
    sig_inc    = (state == ST_SIG_RD || state == ST_SIG_WR) && op_done;
    byte_clr   = start_acc || (state == ST_COMMIT && op_done);
    byte_inc   = (state == ST_LOAD) && op_done;
    page_inc   = (state == ST_COMMIT) && op_done;
    sig_byte   = sig_expected[{sig_cnt, 3'b000} +: 8];
  end

  // Operation presented for the current state
  always_comb begin
    op_state = 1'b1;
    op_mode  = MD_IDLE;
    op_addr  = '0;
    op_data  = 8'h00;
    op_pulse = 1'b1;
    case (state)
      ST_SIG_RD: begin op_mode = MD_SIG_RD; op_addr = ADDR_W'(sig_cnt); op_pulse = 1'b0; end
      ST_SEC_RD: begin op_mode = MD_SEC_RD; op_pulse = 1'b0; end
      ST_UNLK_A: begin op_mode = MD_UNLOCK; op_data = KEY_FIRST; end
      ST_UNLK_B: begin op_mode = MD_UNLOCK; op_data = KEY_SECOND; end
      ST_ERASE:  op_mode = MD_ERASE;
      ST_SEC_WR: begin op_mode = MD_SEC_WR; op_data = BYTE_BLANK; end
      ST_SIG_WR: begin op_mode = MD_SIG_WR; op_addr = ADDR_W'(sig_cnt); op_data = sig_byte; end
      ST_LOCK:   op_mode = MD_LOCK;
      ST_LOAD:   begin op_mode = MD_PG_LOAD; op_addr = ADDR_W'({page_cnt, byte_cnt}); op_data = byte_q; end
      ST_COMMIT: begin op_mode = MD_PG_COMMIT; op_addr = ADDR_W'({page_cnt, BYTE_IDX_W'(0)}); end
      default:   op_state = 1'b0;
    endcase
    launch = op_state && !issued;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      unlk_ret     <= RET_LOAD;
      lock_final   <= 1'b0;
      issued       <= 1'b0;
      go           <= 1'b0;
      pulse_req    <= 1'b0;
      pages_q      <= '0;
      byte_q       <= 8'h00;
      in_ready     <= 1'b0;
      tgt_mode     <= MD_IDLE;
      tgt_addr     <= '0;
      tgt_wdata    <= 8'h00;
      tgt_wdata_oe <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      error        <= 1'b0;
    end else begin
      go <= 1'b0;
      if (launch) begin
        issued       <= 1'b1;
        go           <= 1'b1;
        pulse_req    <= op_pulse;
        tgt_mode     <= op_mode;
        tgt_addr     <= op_addr;
        tgt_wdata    <= op_data;
        tgt_wdata_oe <= op_pulse;
      end
      if (op_done) issued <= 1'b0;

      case (state)
        ST_IDLE, ST_DONE, ST_ERROR: if (start) begin
          pages_q <= num_pages;
          done    <= 1'b0;
          error   <= 1'b0;
          busy    <= 1'b1;
          state   <= ST_SIG_RD;
        end
        ST_SIG_RD: if (op_done) begin
          if (tgt_rdata != sig_byte) begin
            state        <= ST_ERROR;
            error        <= 1'b1;
            busy         <= 1'b0;
            tgt_mode     <= MD_IDLE;
            tgt_wdata_oe <= 1'b0;
          end else if (sig_last) state <= ST_SEC_RD;
        end
        ST_SEC_RD: if (op_done) begin
          if (tgt_rdata != BYTE_BLANK) begin
            unlk_ret <= RET_ERASE;
            state    <= ST_UNLK_A;
          end else if (pages_q == '0) begin
            lock_final <= 1'b1;
            state      <= ST_LOCK;
          end else begin
            unlk_ret <= RET_LOAD;
            state    <= ST_UNLK_A;
          end
        end
        ST_UNLK_A: if (op_done) state <= ST_UNLK_B;
        ST_UNLK_B: if (op_done) begin
          case (unlk_ret)
            RET_ERASE:  state <= ST_ERASE;
            RET_COMMIT: state <= ST_COMMIT;
            default:    state <= ST_WAIT_BYTE;
          endcase
        end
        ST_ERASE:  if (op_done) state <= ST_SEC_WR;
        ST_SEC_WR: if (op_done) state <= ST_SIG_WR;
        ST_SIG_WR: if (op_done && sig_last) begin
          lock_final <= (pages_q == '0);
          state      <= ST_LOCK;
        end
        ST_LOCK: if (op_done) begin
          if (lock_final) begin
            state        <= ST_DONE;
            done         <= 1'b1;
            busy         <= 1'b0;
            tgt_mode     <= MD_IDLE;
            tgt_wdata_oe <= 1'b0;
          end else begin
            unlk_ret <= RET_LOAD;
            state    <= ST_UNLK_A;
          end
        end
        ST_WAIT_BYTE: begin
          if (in_ready && in_valid) begin
            byte_q   <= in_data;
            in_ready <= 1'b0;
            state    <= ST_LOAD;
          end else begin
            in_ready <= 1'b1;
          end
        end
        ST_LOAD: if (op_done) begin
          if (byte_last) begin
            unlk_ret <= RET_COMMIT;
            state    <= ST_UNLK_A;
          end else state <= ST_WAIT_BYTE;
        end
        ST_COMMIT: if (op_done) begin
          if (page_last) begin
            lock_final <= 1'b1;
            state      <= ST_LOCK;
          end else begin
            unlk_ret <= RET_LOAD;
            state    <= ST_UNLK_A;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  prog_step_counter #(.W(SIG_IDX_W)) u_sig_cnt (
    .clk(clk), .rst(rst), .clr(sig_clr), .inc(sig_inc),
    .limit(SIG_IDX_W'(SIG_BYTES - 1)), .count(sig_cnt), .last(sig_last)
  );

  prog_step_counter #(.W(BYTE_IDX_W)) u_byte_cnt (
    .clk(clk), .rst(rst), .clr(byte_clr), .inc(byte_inc),
    .limit(BYTE_IDX_W'(PAGE_BYTES - 1)), .count(byte_cnt), .last(byte_last)
  );

  prog_step_counter #(.W(PAGE_CNT_W)) u_page_cnt (
    .clk(clk), .rst(rst), .clr(start_acc), .inc(page_inc),
    .limit(pages_q - 1'b1), .count(page_cnt), .last(page_last)
  );

  prog_strobe_gen #(
    .SETUP_CYC(SETUP_CYC), .WIDTH_CYC(WIDTH_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_strobe (
    .clk(clk), .rst(rst), .go(go), .with_pulse(pulse_req),
    .strobe_n(tgt_strobe_n), .fin(pulse_fin)
  );

endmodule

// File: rtl/prog_seq_checker.sv
module prog_seq_checker #(
  parameter int ADDR_W    = 16,
  parameter int WIDTH_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tgt_strobe_n,
  input logic [3:0]        tgt_mode,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic [7:0]        tgt_wdata,
  input logic              in_valid,
  input logic              in_ready,
  input logic              busy,
  input logic              done,
  input logic              error
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)                low_run <= '0;
    else if (!tgt_strobe_n) low_run <= low_run + 16'd1;
    else                    low_run <= '0;
  end

  a_r6_hold_while_low: assert property (@(posedge clk) disable iff (rst)
    (!tgt_strobe_n && !$past(tgt_strobe_n)) |->
      ($stable(tgt_addr) && $stable(tgt_wdata) && $stable(tgt_mode)));

  a_r6_stable_at_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(tgt_strobe_n) |-> ($stable(tgt_addr) && $stable(tgt_mode) && $stable(tgt_wdata)));

  a_r6_low_width: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_strobe_n) |-> (low_run == 16'(WIDTH_CYC)));

  a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r9_error_quiet: assert property (@(posedge clk) disable iff (rst)
    error |-> (tgt_strobe_n && !busy));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !error && tgt_strobe_n));

endmodule

bind flash_prog_seq prog_seq_checker #(
  .ADDR_W(ADDR_W), .WIDTH_CYC(WIDTH_CYC)
) u_prog_seq_checker (
  .clk(clk), .rst(rst), .tgt_strobe_n(tgt_strobe_n), .tgt_mode(tgt_mode),
  .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .in_valid(in_valid),
  .in_ready(in_ready), .busy(busy), .done(done), .error(error)
);

// File: tb/flash_prog_seq_bench.sv
`timescale 1ns/1ps
module flash_prog_seq_bench;

  localparam int ADDR_W = 16, PB = 128, SIGN = 2, PCW = 8;
  localparam int SETUP = 2, WIDTH = 3, HOLD = 2;
  localparam int MEMN = 4 * PB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              start = 1'b0;
  logic [PCW-1:0]    num_pages = '0;
  logic [15:0]       sig_expected = '0;
  logic              in_valid = 1'b0;
  logic [7:0]        in_data = '0;
  logic              in_ready;
  logic [7:0]        tgt_rdata;
  logic [3:0]        tgt_mode;
  logic [ADDR_W-1:0] tgt_addr;
  logic [7:0]        tgt_wdata;
  logic              tgt_wdata_oe, tgt_strobe_n, busy, done, error;

  flash_prog_seq #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PB), .SIG_BYTES(SIGN), .PAGE_CNT_W(PCW),
    .SETUP_CYC(SETUP), .WIDTH_CYC(WIDTH), .HOLD_CYC(HOLD)
  ) u_flash_prog_seq (
    .clk(clk), .rst(rst), .start(start), .num_pages(num_pages),
    .sig_expected(sig_expected), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tgt_rdata(tgt_rdata), .tgt_mode(tgt_mode),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_wdata_oe(tgt_wdata_oe),
    .tgt_strobe_n(tgt_strobe_n), .busy(busy), .done(done), .error(error)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- target model ----------------
  logic [7:0] t_sig [SIGN];
  logic [7:0] t_sec;
  logic [7:0] t_mem [MEMN];
  logic [7:0] t_buf [PB];
  int         t_unlk = 0;

  always_comb begin
    if (tgt_mode == 4'd1)      tgt_rdata = t_sig[tgt_addr[0]];
    else if (tgt_mode == 4'd2) tgt_rdata = t_sec;
    else                       tgt_rdata = 8'h00;
  end

  logic [3:0]        log_mode [1024];
  logic [7:0]        log_data [1024];
  logic [ADDR_W-1:0] log_addr [1024];
  int                n_pulse = 0;

  always @(negedge tgt_strobe_n) begin
    log_mode[n_pulse] = tgt_mode;
    log_data[n_pulse] = tgt_wdata;
    log_addr[n_pulse] = tgt_addr;
    n_pulse++;
    case (tgt_mode)
      4'd3: begin
        if (tgt_wdata == 8'h55) t_unlk = 1;
        else if (tgt_wdata == 8'hAA && t_unlk == 1) t_unlk = 2;
        else t_unlk = 0;
      end
      4'd4: if (t_unlk == 2) begin
        for (int i = 0; i < MEMN; i++) t_mem[i] = 8'hFF;
        for (int i = 0; i < SIGN; i++) t_sig[i] = 8'hFF;
      end
      4'd5: t_sec = tgt_wdata;
      4'd6: t_sig[tgt_addr[0]] = tgt_wdata;
      4'd7: t_unlk = 0;
      4'd8: t_buf[tgt_addr[6:0]] = tgt_wdata;
      4'd9: if (t_unlk == 2)
        for (int i = 0; i < PB; i++) t_mem[{tgt_addr[8:7], 7'd0} + i] = t_buf[i];
      default: ;
    endcase
  end

  // ---------------- timing / handshake monitor ----------------
  int hi_same = 0, low_cnt = 0, setup_viol = 0, width_viol = 0, stab_viol = 0;
  int accepted = 0, ready_viol = 0;
  logic [27:0] prev_v = '0, low_ref = '0;
  logic prev_stb = 1'b1, prev_acc = 1'b0;

  always @(negedge clk) begin
    logic [27:0] cur;
    cur = {tgt_mode, tgt_addr, tgt_wdata};
    if (!rst) begin
      if (tgt_strobe_n) begin
        if (!prev_stb && low_cnt != WIDTH) width_viol++;
        low_cnt = 0;
        hi_same = (cur != prev_v) ? 1 : hi_same + 1;
      end else begin
        low_cnt++;
        if (prev_stb) begin
          if (hi_same < SETUP || cur != prev_v) setup_viol++;
          low_ref = cur;
        end else if (cur != low_ref) stab_viol++;
      end
      if (prev_acc && in_ready) ready_viol++;
      prev_acc = in_valid && in_ready;
      if (prev_acc) accepted++;
    end
    prev_v = cur;
    prev_stb = tgt_strobe_n;
  end

  // ---------------- helpers ----------------
  function automatic logic [7:0] pat(int p, int i);
    return 8'((p * 29 + i * 7 + 17) & 255);
  endfunction

  task automatic session_prep(logic [7:0] s0, logic [7:0] s1, logic [7:0] sec);
    t_sig[0] = s0; t_sig[1] = s1; t_sec = sec; t_unlk = 0;
    for (int i = 0; i < MEMN; i++) t_mem[i] = 8'h00;
    n_pulse = 0; accepted = 0;
  endtask

  task automatic do_start(int pages, logic [15:0] sig);
    @(negedge clk);
    num_pages = PCW'(pages); sig_expected = sig; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(int pages);
    for (int p = 0; p < pages; p++)
      for (int i = 0; i < PB; i++) begin
        if (i % 5 == 3) begin
          in_valid = 1'b0;
          repeat (2) @(negedge clk);
        end
        in_valid = 1'b1; in_data = pat(p, i);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
      end
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || error) && n < 20000) begin @(negedge clk); n++; end
  endtask

  function automatic int mem_errs(int pages);
    int e = 0;
    for (int p = 0; p < pages; p++)
      for (int i = 0; i < PB; i++)
        if (t_mem[p * PB + i] !== pat(p, i)) e++;
    return e;
  endfunction

  // Checks a page block in the log starting at index b for page p (R5)
  function automatic int page_log_errs(int b, int p);
    int e = 0;
    if (log_mode[b] != 4'd3 || log_data[b] != 8'h55) e++;
    if (log_mode[b+1] != 4'd3 || log_data[b+1] != 8'hAA) e++;
    for (int i = 0; i < PB; i++)
      if (log_mode[b+2+i] != 4'd8 || log_addr[b+2+i] != 16'(p*PB+i) ||
          log_data[b+2+i] != pat(p, i)) e++;
    if (log_mode[b+PB+2] != 4'd3 || log_data[b+PB+2] != 8'h55) e++;
    if (log_mode[b+PB+3] != 4'd3 || log_data[b+PB+3] != 8'hAA) e++;
    if (log_mode[b+PB+4] != 4'd9 || log_addr[b+PB+4] != 16'(p*PB)) e++;
    return e;
  endfunction

  // ---------------- scenarios ----------------
  task automatic test_reset();
    @(negedge clk);
    chk("R1 strobe_n", int'(tgt_strobe_n), 1);
    chk("R1 mode", int'(tgt_mode), 0);
    chk("R1 flags", int'({tgt_wdata_oe, in_ready, busy, done, error}), 0);
  endtask

  task automatic test_sig_mismatch();
    session_prep(8'h1E, 8'h7C, 8'h00);
    do_start(1, 16'h7D1E);
    wait_end();
    repeat (20) @(negedge clk);
    chk("R2 mismatch raises error", int'(error), 1);
    chk("R2 no pulse after mismatch", n_pulse, 0);
    chk("R9 error state quiet", int'({busy, done, tgt_strobe_n}), 3'b001);
  endtask

  task automatic test_unprotected();
    bit ok = 1;
    session_prep(8'h1E, 8'h7C, 8'hFF);
    do_start(1, 16'h7C1E);
    fork
      feed(1);
      begin
        repeat (300) @(negedge clk);
        start = 1'b1; num_pages = 8'd3;
        @(negedge clk);
        start = 1'b0;
      end
    join
    wait_end();
    chk("R3 no recovery, pulse count", n_pulse, 134);
    for (int i = 0; i < n_pulse; i++) if (log_mode[i] == 4'd4) ok = 0;
    chk("R3 no erase pulse", int'(ok), 1);
    chk("R5 page log order", page_log_errs(0, 0), 0);
    chk("R5 page contents", mem_errs(1), 0);
    chk("R7 bytes accepted", accepted, PB);
    chk("R8 final lock", int'(log_mode[133]), 7);
    chk("R10 start ignored while busy", int'({done, error}), 2'b10);
    repeat (10) @(negedge clk);
    chk("R8 done holds", int'({done, busy, tgt_strobe_n}), 3'b101);
  endtask

  task automatic test_protected();
    int e = 0;
    session_prep(8'h1E, 8'h7C, 8'h3C);
    do_start(2, 16'h7C1E);
    feed(2);
    wait_end();
    chk("R4 pulse count", n_pulse, 7 + 2 * (PB + 5) + 1);
    if (log_mode[0] != 4'd3 || log_data[0] != 8'h55) e++;
    if (log_mode[1] != 4'd3 || log_data[1] != 8'hAA) e++;
    if (log_mode[2] != 4'd4) e++;
    if (log_mode[3] != 4'd5 || log_data[3] != 8'hFF) e++;
    if (log_mode[4] != 4'd6 || log_addr[4] != 16'd0 || log_data[4] != 8'h1E) e++;
    if (log_mode[5] != 4'd6 || log_addr[5] != 16'd1 || log_data[5] != 8'h7C) e++;
    if (log_mode[6] != 4'd7) e++;
    chk("R4 recovery order", e, 0);
    chk("R4 security cleared", int'(t_sec), 8'hFF);
    chk("R4 signature restored", int'({t_sig[1], t_sig[0]}), 16'h7C1E);
    chk("R5 page 0 log", page_log_errs(7, 0), 0);
    chk("R5 page 1 log", page_log_errs(7 + PB + 5, 1), 0);
    chk("R5 contents two pages", mem_errs(2), 0);
    chk("R7 bytes accepted", accepted, 2 * PB);
    chk("R8 done", int'({done, error, busy}), 3'b100);
  endtask

  task automatic test_zero_pages();
    session_prep(8'h1E, 8'h7C, 8'hFF);
    do_start(0, 16'h7C1E);
    wait_end();
    chk("R3 zero pages: one pulse", n_pulse, 1);
    chk("R8 zero pages: lock then done", int'({log_mode[0], done}), {4'd7, 1'b1});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_sig_mismatch();
    test_unprotected();
    test_protected();
    test_zero_pages();
    chk("R6 setup window", setup_viol, 0);
    chk("R6 strobe width", width_viol, 0);
    chk("R6 stable while low", stab_viol, 0);
    chk("R7 ready drops after accept", ready_viol, 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule